// File: doc/BRIEF.md
# Two-Way Translation Lookaside Buffer

This block holds recent virtual-to-real page translations in 64 sets of two lines each. The two lines of a set are called W and X. Each line stores a virtual word and a real word. The virtual word carries a page tag and two valid flags, one for user mode and one for supervisor mode. The real word carries the real page address and its attribute flags. One recency bit per set records whether W or X was touched last, and the line it does not name is the one replaced.

A lookup request carries a virtual address, a user/supervisor mode bit and a write bit. One clock later the block returns a result: whether it hit, which line it chose, and the real word. On a miss the chosen line is the replacement victim, which an outside page-table walker fills through the fill port. A bulk command port clears chosen flag classes across every entry at once.

The lookup and fill ports use valid/ready handshakes. A lookup is accepted only when all of these hold:
- the result register is empty, or is being drained in the same cycle;
- no fill is offered;
- no command is offered.

A result stays on the outputs until `res_ready` takes it. The command port has priority over the fill port, and the fill port has priority over lookups.

Top module: `xlat_cache`

## Requirements
- R1: After reset, `res_valid` is low and every entry is invalid, so any lookup misses and reports line W (0).
- R2: The set index is virtual address bits 17:12 and the tag is bits 31:18. A hit needs a tag match and the valid flag of the request's mode: virtual-word bit 1 for user, bit 2 for supervisor.
- R3: A hit returns the line's real word with the referenced flag (bit 1) set. A write hit also sets the dirty flag (bit 2). Both flags stay in the entry.
- R4: A hit on W sets the set's recency bit and a hit on X clears it. A miss leaves the bit unchanged and reports the victim in `res_way` (0 = W, 1 = X): X when the bit is set, W when it is clear.
- R5: A fill writes the victim line of the set indexed by `fill_vaddr`, taking the tag and the valid flags from the fill inputs and the real word as given. It then marks that line most recently used.
- R6: Command bit 2 clears every supervisor-valid flag, and command bit 3 clears every user-valid flag.
- R7: Command bit 4 clears every dirty flag, and command bit 5 clears every referenced flag.
- R8: Command bit 6 clears every recency bit. Command bits 0 and 1 have no effect on any entry.
- R9: `lk_ready` equals (`!res_valid || res_ready`) and is low while a fill or a command is offered. Each accepted lookup gives `res_valid` on the next cycle. A result held against a low `res_ready` stays unchanged.
- R10: `fill_ready` is low while `cmd_valid` is high. A command is always taken in its cycle.
- R11: A miss returns a real word of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request offered |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| lk_write | input | 1 | Access is a write |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer ready |
| res_hit | output | 1 | Lookup hit |
| res_way | output | 1 | Hit line, or victim on miss (0 = W, 1 = X) |
| res_rword | output | 32 | Updated real word on hit, zero on miss |
| fill_valid | input | 1 | Fill offered |
| fill_ready | output | 1 | Fill can be taken |
| fill_vaddr | input | 32 | Virtual address being filled |
| fill_uv | input | 1 | User-valid flag for the new line |
| fill_sv | input | 1 | Supervisor-valid flag for the new line |
| fill_rword | input | 32 | Real word for the new line |
| cmd_valid | input | 1 | Bulk flag-clear command |
| cmd_bits | input | 7 | Command bits, decoded as in R6 to R8 |

## Verification
On every cycle, the assertions check the handshake rules: results are held under back-pressure, every accepted lookup yields a result, and commands block the fill and lookup ports. They also check that every hit carries the referenced flag, that write hits carry the dirty flag, and that misses return zero. The bench scenarios are needed for the behaviour that depends on stored state: replacement order driven by the recency bit, fills landing in the victim line, and the per-class effects of each command bit. Those show only when a lookup is made after the state has changed.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PAGE_LO   = 12;
  localparam int VW_UV     = 1;
  localparam int VW_SV     = 2;
  localparam int RW_REF    = 1;
  localparam int RW_DIRTY  = 2;
  localparam int CMD_W     = 7;
  localparam int CMD_CLR_SV  = 2;
  localparam int CMD_CLR_UV  = 3;
  localparam int CMD_CLR_D   = 4;
  localparam int CMD_CLR_R   = 5;
  localparam int CMD_CLR_REC = 6;

  typedef enum logic { LINE_W = 1'b0, LINE_X = 1'b1 } line_e;
endpackage

// File: rtl/xlat_way_match.sv
module xlat_way_match #(
  parameter int TAG_LO = 18
) (
  input  logic [31:0]        vword,
  input  logic [31-TAG_LO:0] tag,
  input  logic               user,
  output logic               hit
);
  import xlat_pkg::*;
  logic mode_ok;
  always_comb begin
    mode_ok = user ? vword[VW_UV] : vword[VW_SV];
    hit     = (vword[31:TAG_LO] == tag) && mode_ok;
  end
endmodule

// File: rtl/xlat_store.sv
module xlat_store #(
  parameter int SETS  = 64,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [1:0][31:0] lk_vw,
  output logic [1:0][31:0] lk_rw,
  output logic             lk_rec,
  input  logic             hit_fire,
  input  logic             hit_way,
  input  logic             hit_write,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_fire,
  input  logic [31:0]      fill_vw,
  input  logic [31:0]      fill_rw,
  input  logic             cmd_fire,
  input  logic [6:0]       cmd_bits
);
  import xlat_pkg::*;

  logic [31:0]     vw_q [SETS][2];
  logic [31:0]     rw_q [SETS][2];
  logic [SETS-1:0] rec_q;
  logic            fill_way;

  for (genvar w = 0; w < 2; w++) begin : g_rd
    assign lk_vw[w] = vw_q[lk_idx][w];
    assign lk_rw[w] = rw_q[lk_idx][w];
  end
  assign lk_rec   = rec_q[lk_idx];
  // recency set means W was last used, so X is the victim
  assign fill_way = rec_q[fill_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < 2; w++) begin
          vw_q[s][w] <= '0;
          rw_q[s][w] <= '0;
        end
      end
      rec_q <= '0;
    end else if (cmd_fire) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < 2; w++) begin
          if (cmd_bits[CMD_CLR_SV]) vw_q[s][w][VW_SV]    <= 1'b0;
          if (cmd_bits[CMD_CLR_UV]) vw_q[s][w][VW_UV]    <= 1'b0;
          if (cmd_bits[CMD_CLR_D])  rw_q[s][w][RW_DIRTY] <= 1'b0;
          if (cmd_bits[CMD_CLR_R])  rw_q[s][w][RW_REF]   <= 1'b0;
        end
        if (cmd_bits[CMD_CLR_REC]) rec_q[s] <= 1'b0;
      end
    end else if (fill_fire) begin
      vw_q[fill_idx][fill_way] <= fill_vw;
      rw_q[fill_idx][fill_way] <= fill_rw;
      rec_q[fill_idx]          <= (fill_way == LINE_W);
    end else if (hit_fire) begin
      rw_q[lk_idx][hit_way][RW_REF] <= 1'b1;
      if (hit_write) rw_q[lk_idx][hit_way][RW_DIRTY] <= 1'b1;
      rec_q[lk_idx] <= (hit_way == LINE_W);
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int SETS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [31:0] lk_vaddr,
  input  logic        lk_user,
  input  logic        lk_write,
  output logic        res_valid,
  input  logic        res_ready,
  output logic        res_hit,
  output logic        res_way,
  output logic [31:0] res_rword,
  input  logic        fill_valid,
  output logic        fill_ready,
  input  logic [31:0] fill_vaddr,
  input  logic        fill_uv,
  input  logic        fill_sv,
  input  logic [31:0] fill_rword,
  input  logic        cmd_valid,
  input  logic [6:0]  cmd_bits
);
  import xlat_pkg::*;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_LO = PAGE_LO + IDX_W;

  logic [1:0][31:0] lk_vw, lk_rw;
  logic [1:0]       way_hit;
  logic             lk_rec, lk_fire, fill_fire, any_hit, hit_way;
  logic [31:0]      upd_rw, fill_vw;

  assign fill_ready = !cmd_valid;
  assign fill_fire  = fill_valid && fill_ready;
  assign lk_ready   = (!res_valid || res_ready) && !cmd_valid && !fill_valid;
  assign lk_fire    = lk_valid && lk_ready;

  for (genvar w = 0; w < 2; w++) begin : g_way
    xlat_way_match #(.TAG_LO(TAG_LO)) u_match (
      .vword (lk_vw[w]),
      .tag   (lk_vaddr[31:TAG_LO]),
      .user  (lk_user),
      .hit   (way_hit[w])
    );
  end

  always_comb begin
    any_hit = |way_hit;
    hit_way = !way_hit[0];
    upd_rw  = lk_rw[hit_way];
    upd_rw[RW_REF] = 1'b1;
    if (lk_write) upd_rw[RW_DIRTY] = 1'b1;
    fill_vw = {fill_vaddr[31:TAG_LO], {(TAG_LO-3){1'b0}}, fill_sv, fill_uv, 1'b0};
  end

  xlat_store #(.SETS(SETS), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (lk_vaddr[TAG_LO-1:PAGE_LO]),
    .lk_vw     (lk_vw),
    .lk_rw     (lk_rw),
    .lk_rec    (lk_rec),
    .hit_fire  (lk_fire && any_hit),
    .hit_way   (hit_way),
    .hit_write (lk_write),
    .fill_idx  (fill_vaddr[TAG_LO-1:PAGE_LO]),
    .fill_fire (fill_fire),
    .fill_vw   (fill_vw),
    .fill_rw   (fill_rword),
    .cmd_fire  (cmd_valid),
    .cmd_bits  (cmd_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_way   <= 1'b0;
      res_rword <= '0;
    end else if (lk_fire) begin
      res_valid <= 1'b1;
      res_hit   <= any_hit;
      res_way   <= any_hit ? hit_way : lk_rec;
      res_rword <= any_hit ? upd_rw : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic        lk_write,
  input logic        res_valid,
  input logic        res_ready,
  input logic        res_hit,
  input logic        res_way,
  input logic [31:0] res_rword,
  input logic        fill_ready,
  input logic        cmd_valid
);
  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) && $stable(res_way) && $stable(res_rword));

  assert_accept_gives_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> res_valid);

  assert_hit_referenced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> res_rword[1]);

  assert_write_hit_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && lk_write |=> !res_hit || res_rword[2]);

  assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_rword == 32'h0);

  assert_cmd_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !fill_ready && !lk_ready);
endmodule

bind xlat_cache xlat_cache_chk u_chk (.*);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_user = 0, lk_write = 0, res_ready = 1;
  logic [31:0] lk_vaddr = '0;
  logic fill_valid = 0, fill_uv = 0, fill_sv = 0, cmd_valid = 0;
  logic [31:0] fill_vaddr = '0, fill_rword = '0;
  logic [6:0] cmd_bits = '0;
  logic lk_ready, res_valid, res_hit, res_way, fill_ready;
  logic [31:0] res_rword;

  int total = 0, bad = 0;
  logic [33:0] exp_q [$];
  string       req_q [$];

  always #4 clk = ~clk;

  xlat_cache uut (.*);

  localparam logic [31:0] VA_A = 32'h0001_2000;
  localparam logic [31:0] VA_B = 32'h0005_2000;
  localparam logic [31:0] VA_C = 32'h0009_2000;
  localparam logic [31:0] RW1  = 32'h1234_5038;
  localparam logic [31:0] RW2  = 32'hABCD_E200;

  task automatic check(string req, logic [33:0] act, logic [33:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a result is consumed
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) check("R9", {res_hit, res_way, res_rword}, 34'h3_FFFF_FFFF);
      else check(req_q.pop_front(), {res_hit, res_way, res_rword}, exp_q.pop_front());
    end
  end

  task automatic lookup(string req, logic [31:0] va, logic user, logic wr,
                        logic hit, logic way, logic [31:0] rw);
    @(negedge clk);
    exp_q.push_back({hit, way, rw});
    req_q.push_back(req);
    lk_vaddr = va; lk_user = user; lk_write = wr; lk_valid = 1'b1;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic fill(logic [31:0] va, logic uv, logic sv, logic [31:0] rw);
    @(negedge clk);
    fill_vaddr = va; fill_uv = uv; fill_sv = sv; fill_rword = rw; fill_valid = 1'b1;
    while (!fill_ready) @(negedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic command(logic [6:0] bits);
    @(negedge clk);
    cmd_bits = bits; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {33'b0, res_valid}, 34'b0);
    check("R9", {33'b0, lk_ready}, 34'b1);
    lookup("R1", VA_A, 1, 0, 0, 0, 32'h0);
    fill(VA_A, 1, 0, RW1);                                    // R5 into W
    lookup("R2", VA_A, 1, 0, 1, 0, RW1 | 32'h2);
    lookup("R4", VA_A, 0, 0, 0, 1, 32'h0);                    // R2 supervisor invalid, victim X
    lookup("R3", VA_A, 1, 1, 1, 0, RW1 | 32'h6);
    lookup("R11", VA_B, 1, 0, 0, 1, 32'h0);
    fill(VA_B, 1, 1, RW2);                                    // R5 into X
    lookup("R3", VA_A, 1, 0, 1, 0, RW1 | 32'h6);
    lookup("R5", VA_B, 0, 0, 1, 1, RW2 | 32'h2);
    lookup("R4", VA_C, 1, 0, 0, 0, 32'h0);
    command(7'h30);
    lookup("R7", VA_A, 1, 0, 1, 0, RW1 | 32'h2);
    command(7'h40);
    lookup("R8", VA_C, 1, 0, 0, 0, 32'h0);
    command(7'h04);
    lookup("R6", VA_B, 0, 0, 0, 0, 32'h0);
    lookup("R6", VA_B, 1, 0, 1, 1, RW2 | 32'h2);
    command(7'h08);
    lookup("R6", VA_A, 1, 0, 0, 0, 32'h0);
    fill(VA_A, 1, 0, RW1);
    command(7'h03);
    lookup("R8", VA_A, 1, 0, 1, 0, RW1 | 32'h2);
    lookup("R8", VA_B, 1, 0, 0, 1, 32'h0);

    // R9 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    exp_q.push_back({1'b1, 1'b0, RW1 | 32'h2});
    req_q.push_back("R9");
    lk_vaddr = VA_A; lk_user = 1; lk_write = 0; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R9", {res_valid, lk_ready, res_hit, res_way, 30'b0}, {4'b1010, 30'b0});
      check("R9", {2'b0, res_rword}, {2'b0, RW1 | 32'h2});
      @(negedge clk);
    end
    res_ready = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", {33'b0, res_valid}, 34'b0);

    // R10 priority
    cmd_valid = 1'b1; cmd_bits = 7'h00; fill_valid = 1'b1; fill_vaddr = VA_C;
    #1;
    check("R10", {32'b0, fill_ready, lk_ready}, 34'b0);
    @(negedge clk);
    cmd_valid = 1'b0; fill_valid = 1'b0;
    #1;
    check("R10", {32'b0, fill_ready, lk_ready}, 34'b11);
    repeat (2) @(negedge clk);
    check("R9", {33'b0, exp_q.size() == 0}, 34'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule